// File: doc/BRIEF.md
# Register-Programmed MDIO Management Master

This block is a Clause 22 MDIO master that software drives through three small registers. A location register holds the target PHY and register number. A port-mode register marks which of the low PHY addresses may be reached with Clause 22 frames. Software launches a transfer by writing a command word with the busy flag set. The block then emits the management frame on MDC/MDIO, captures read data from the PHY, and drops the busy flag when the last bit is done.

MDC is produced from the system clock. The half-period is picked per command by a clock-range field in the command word. A command aimed at an address that is not allowed, or a malformed command, finishes at once with an error flag set and no bus activity. The register interface is a plain single-cycle write strobe plus a combinational read mux. It has no back-pressure: software sees when the block can take a command by polling the busy flag.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset all three registers read zero, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: A command write (select 1) with bit 22 set, bit 18 set and operation bits 17:16 = 01 sends a write frame MSB first: 32 ones, 01, 01, the PHY address, the register number, 10, then data bits 15:0 of the command word.
- R3: Operation bits 17:16 = 11 sends a read frame (32 ones, 01, 10, PHY address, register number). The 16 data bits are sampled on MDC rising edges. They are returned in bits 15:0 of the command register once busy has cleared.
- R4: Command-register bit 22 (busy) reads 1 from the cycle after an accepted launch until the frame ends. It then clears in the same cycle as the last MDC falling edge.
- R5: The master changes MDIO (value or enable) only on a cycle where MDC falls or where a transfer is launched.
- R6: The MDC half-period is 2 << S system clocks, where S is the clock-range field in command bits 21:19.
- R7: The location register (select 0) keeps the PHY address in bits 20:16 and the register number in bits 4:0. The port-mode register (select 2) keeps one Clause 22 enable per port in bits 3:0. A command to a PHY address above 3, or to a port whose enable is clear, produces no frame, leaves busy at 0 and sets the error flag in bit 23.
- R8: A command with bit 18 clear, or with operation bits 01 or 11 absent, is rejected in the same way as R7.
- R9: A command write while busy is set is ignored. The running frame is unchanged, no second frame follows, and the stored data field is kept.
- R10: MDIO is released whenever no transfer runs. During a read it is also released from the first turnaround bit to the end of the frame.
- R11: The error flag clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 location, 1 command, 2 port mode |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 drives the pin) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bound checker watches a set of rules on every cycle. It checks that MDIO moves only with an MDC fall or a launch, and that busy holds until the engine signals the end of the frame and then clears. It also checks that MDC and the MDIO enable stay quiet while idle, and that a raised error flag never coexists with a running transfer. Only the bench scenarios can show the bit content of each frame, the returned read value, and the measured MDC half-period for a given range setting. The same holds for the choice between accepting and rejecting a command, and for the ignored mid-frame command leaving the frame and data untouched.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  // register selects
  localparam logic [1:0] SEL_LOC  = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_PORT = 2'd2;

  // command word bit positions
  localparam int CMD_ERR   = 23;
  localparam int CMD_BUSY  = 22;
  localparam int CMD_CSHI  = 21;
  localparam int CMD_CSLO  = 19;
  localparam int CMD_C22   = 18;
  localparam int CMD_OPHI  = 17;
  localparam int CMD_OPLO  = 16;

  localparam logic [1:0] HOP_WR = 2'b01;
  localparam logic [1:0] HOP_RD = 2'b11;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdata;
    logic [2:0]  csel;
  } mdio_req_t;
endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_mgmt_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        done,
  input  logic [15:0] rdata,
  output mdio_req_t   req,
  output logic        start,
  output logic        busy,
  output logic        err
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [4:0]       phy_q, regn_q;
  logic [NPORT-1:0] port_q;
  logic [2:0]       csel_q;
  logic             c22_q;
  logic [1:0]       op_q;
  logic [15:0]      data_q;
  logic             busy_q, err_q;

  logic       cmd_go, cmd_ok, port_ok, op_ok;
  logic [1:0] op_in;

  assign op_in   = wr_data[CMD_OPHI:CMD_OPLO];
  assign cmd_go  = wr_en && (wr_sel == SEL_CMD) && wr_data[CMD_BUSY] && !busy_q;
  assign op_ok   = (op_in == HOP_WR) || (op_in == HOP_RD);
  assign port_ok = (phy_q < 5'(NPORT)) && port_q[phy_q[PW-1:0]];
  assign cmd_ok  = wr_data[CMD_C22] && op_ok && port_ok;
  assign start   = cmd_go && cmd_ok;

  assign req.rd    = (op_in == HOP_RD);
  assign req.phy   = phy_q;
  assign req.regn  = regn_q;
  assign req.wdata = wr_data[15:0];
  assign req.csel  = wr_data[CMD_CSHI:CMD_CSLO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q  <= '0;
      regn_q <= '0;
      port_q <= '0;
      csel_q <= '0;
      c22_q  <= 1'b0;
      op_q   <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_LOC) begin
        phy_q  <= wr_data[20:16];
        regn_q <= wr_data[4:0];
      end
      if (wr_en && wr_sel == SEL_PORT)
        port_q <= wr_data[NPORT-1:0];
      if (cmd_go) begin
        csel_q <= wr_data[CMD_CSHI:CMD_CSLO];
        c22_q  <= wr_data[CMD_C22];
        op_q   <= op_in;
        data_q <= wr_data[15:0];
        busy_q <= cmd_ok;
        err_q  <= !cmd_ok;
      end else if (done) begin
        busy_q <= 1'b0;
        if (op_q == HOP_RD)
          data_q <= rdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_LOC: begin
        rd_data[20:16] = phy_q;
        rd_data[4:0]   = regn_q;
      end
      SEL_CMD: begin
        rd_data[CMD_ERR]           = err_q;
        rd_data[CMD_BUSY]          = busy_q;
        rd_data[CMD_CSHI:CMD_CSLO] = csel_q;
        rd_data[CMD_C22]           = c22_q;
        rd_data[CMD_OPHI:CMD_OPLO] = op_q;
        rd_data[15:0]              = data_q;
      end
      SEL_PORT: rd_data[NPORT-1:0] = port_q;
      default:  rd_data = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{wr_data[31:23], wr_data[15:5]};

  assign busy = busy_q;
  assign err  = err_q;
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_BASE = 2,
  parameter int CSEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CSEL_W-1:0] csel,
  output logic              mdc,
  output logic              rise_tk,
  output logic              fall_tk
);
  localparam int CW = $clog2(DIV_BASE) + (1 << CSEL_W);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;
  logic          wrap;

  assign half    = CW'(DIV_BASE) << csel;
  assign wrap    = run && (cnt == half - CW'(1));
  assign rise_tk = wrap && !mdc;
  assign fall_tk = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_req_t   req,
  input  logic        rise_tk,
  input  logic        fall_tk,
  input  logic        mdio_i,
  output logic        run,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rdata
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IW        = $clog2(FRAME_LEN + 1);
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DAT_IDX   = PRE_LEN + 16;

  logic [FRAME_LEN-1:0] frm, load;
  logic [IW-1:0]        idx;
  logic                 rd_q;

  assign load = {{PRE_LEN{1'b1}}, 2'b01, (req.rd ? 2'b10 : 2'b01),
                 req.phy, req.regn, 2'b10, (req.rd ? 16'h0000 : req.wdata)};

  assign mdio_oe = run && !(rd_q && idx >= IW'(TA_IDX));
  assign mdio_o  = mdio_oe && frm[FRAME_LEN-1];
  assign done    = run && fall_tk && (idx == IW'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      rd_q  <= 1'b0;
      idx   <= '0;
      frm   <= '0;
      rdata <= '0;
    end else if (start) begin
      run  <= 1'b1;
      rd_q <= req.rd;
      idx  <= '0;
      frm  <= load;
    end else if (run) begin
      if (rise_tk && rd_q && idx >= IW'(DAT_IDX))
        rdata <= {rdata[14:0], mdio_i};
      if (fall_tk) begin
        if (done) begin
          run <= 1'b0;
        end else begin
          idx <= idx + IW'(1);
          frm <= frm << 1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int DIV_BASE = 2,
  parameter int NPORT    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_req_t   req;
  logic        start, busy, err, frm_done, run, rise_tk, fall_tk;
  logic [15:0] rdata;
  logic [2:0]  csel_run;

  mdio_regfile #(.NPORT(NPORT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .done(frm_done), .rdata(rdata), .req(req), .start(start),
    .busy(busy), .err(err)
  );

  // divider select held for the whole frame
  always_ff @(posedge clk) begin
    if (!rst_n)     csel_run <= '0;
    else if (start) csel_run <= req.csel;
  end

  mdio_clkgen #(.DIV_BASE(DIV_BASE), .CSEL_W(3)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .csel(csel_run),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frm (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(frm_done), .rdata(rdata)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  a_r5_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> ($fell(mdc) || $rose(busy)));

  a_r4_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r4_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  a_r7_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(frm_done), .err(err),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [127:0] exp_q[$];
  int rcnt = 0;
  int frames = 0;
  int half_meas = 0;
  logic [63:0] cap = '0;
  logic [63:0] capm = '0;
  logic [15:0] phy_resp = '0;
  realtime t_rise = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: captures each frame at MDC rise, compares against the scoreboard
  always @(posedge mdc) begin
    int k;
    logic [127:0] e;
    k = (rcnt == 64) ? 0 : rcnt;
    if (k == 0) begin
      cap  = '0;
      capm = '0;
    end
    cap[63-k]  = mdio_oe & mdio_o;
    capm[63-k] = mdio_oe;
    t_rise = $realtime;
    rcnt = k + 1;
    if (rcnt == 64) begin
      frames++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected frame", cap, 64'h0);
      end else begin
        e = exp_q.pop_front();
        chk(cap == e[127:64], "R2/R3 frame bits", cap, e[127:64]);
        chk(capm == e[63:0], "R10 drive mask", capm, e[63:0]);
      end
    end
  end

  // PHY model: turnaround zero and read data, driven after MDC falls
  always @(negedge mdc) begin
    half_meas = int'(($realtime - t_rise) / CLK_PERIOD);
    if (rcnt == 47)
      mdio_i = 1'b0;
    else if (rcnt >= 48 && rcnt <= 63)
      mdio_i = phy_resp[63 - rcnt];
    else
      mdio_i = 1'b1;
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n;
    n = 0;
    do begin
      rd(2'd1, v);
      n++;
    end while (v[22] && n < 20000);
    chk(!v[22], "R4 busy clears after frame", {32'h0, v}, 64'h0);
  endtask

  function automatic logic [31:0] cmd_word(input bit rdop, input logic [2:0] cs,
                                            input logic [15:0] d);
    return {8'h00, 1'b0, 1'b1, cs, 1'b1, (rdop ? 2'b11 : 2'b01), d};
  endfunction

  // driver: pushes the expected frame and launches the command
  task automatic issue(input bit rdop, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input logic [2:0] cs);
    logic [63:0] f, m;
    logic [31:0] v;
    f = {32'hFFFF_FFFF, 2'b01, (rdop ? 2'b10 : 2'b01), phy, rg,
         (rdop ? 18'h0 : {2'b10, d})};
    m = rdop ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    exp_q.push_back({f, m});
    wr(2'd0, {11'h0, phy, 11'h0, rg});
    wr(2'd1, cmd_word(rdop, cs, d));
    rd(2'd1, v);
    chk(v[22] && !v[23], "R4 busy set after launch", {32'h0, v}, 64'h0040_0000);
  endtask

  task automatic reject(input logic [4:0] phy, input logic [31:0] cmd, input string tag);
    logic [31:0] v;
    int f0;
    f0 = frames;
    wr(2'd0, {11'h0, phy, 16'h0003});
    wr(2'd1, cmd);
    rd(2'd1, v);
    chk(!v[22] && v[23], tag, {32'h0, v}, 64'h0080_0000);
    repeat (60) @(negedge clk);
    chk(frames == f0 && !mdc && !mdio_oe, tag, 64'(frames), 64'(f0));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      rd(2'(s), v);
      chk(v == 32'h0, "R1 register reset", {32'h0, v}, 64'h0);
    end
    chk(!mdc && !mdio_oe, "R1 bus idle", {62'h0, mdc, mdio_oe}, 64'h0);

    // R7 field placement
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v);
    chk(v == 32'h001F_001F, "R7 location fields", {32'h0, v}, 64'h001F_001F);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v);
    chk(v == 32'h0000_000F, "R7 port mode field", {32'h0, v}, 64'hF);

    // R2 write frame, R6 half period at range 0
    issue(1'b0, 5'd1, 5'd5, 16'hA5C3, 3'd0);
    wait_idle();
    chk(half_meas == 2, "R6 half period range 0", 64'(half_meas), 64'd2);

    // R6 range 1
    issue(1'b0, 5'd2, 5'd0, 16'h0001, 3'd1);
    wait_idle();
    chk(half_meas == 4, "R6 half period range 1", 64'(half_meas), 64'd4);

    // R3 read
    phy_resp = 16'hBEEF;
    issue(1'b1, 5'd3, 5'd31, 16'h0000, 3'd0);
    wait_idle();
    rd(2'd1, v);
    chk(v[15:0] == 16'hBEEF, "R3 read data", {48'h0, v[15:0]}, 64'hBEEF);
    phy_resp = 16'h1234;
    issue(1'b1, 5'd0, 5'd2, 16'h0000, 3'd0);
    wait_idle();
    rd(2'd1, v);
    chk(v[15:0] == 16'h1234, "R3 read data second", {48'h0, v[15:0]}, 64'h1234);

    // R7 rejections
    reject(5'd5, cmd_word(1'b0, 3'd0, 16'h1111), "R7 address above 3");
    wr(2'd2, 32'h0000_000D);
    reject(5'd1, cmd_word(1'b1, 3'd0, 16'h0000), "R7 port not enabled");

    // R11 accepted command clears error
    issue(1'b0, 5'd0, 5'd7, 16'h5A5A, 3'd0);
    rd(2'd1, v);
    chk(!v[23], "R11 error cleared", {32'h0, v}, 64'h0);
    wait_idle();

    // R8 malformed commands
    reject(5'd0, {8'h00, 1'b0, 1'b1, 3'd0, 1'b0, 2'b01, 16'h2222}, "R8 flag bit 18 clear");
    reject(5'd0, {8'h00, 1'b0, 1'b1, 3'd0, 1'b1, 2'b10, 16'h3333}, "R8 bad operation");

    // R9 command while busy is ignored
    f0 = frames;
    issue(1'b0, 5'd2, 5'd9, 16'hC0DE, 3'd2);
    repeat (100) @(negedge clk);
    wr(2'd1, cmd_word(1'b0, 3'd0, 16'hFFFF));
    rd(2'd1, v);
    chk(v[22] && v[15:0] == 16'hC0DE, "R9 busy kept, data kept", {32'h0, v}, 64'h0040_C0DE);
    wait_idle();
    repeat (100) @(negedge clk);
    rd(2'd1, v);
    chk(v[15:0] == 16'hC0DE, "R9 data after frame", {48'h0, v[15:0]}, 64'hC0DE);
    chk(frames == f0 + 1, "R9 single frame", 64'(frames), 64'(f0 + 1));
    chk(exp_q.size() == 0, "R2 scoreboard drained", 64'(exp_q.size()), 64'h0);

    finish_run();
  end
endmodule